// File: doc/BRIEF.md
# Successive-Cancellation List Path Decision Unit

This unit makes the bit-by-bit decisions of a successive-cancellation list polar decoder and owns the set of candidate paths. For every bit index of a block it receives one signed LLR per path slot and a flag saying whether the index is frozen. On a frozen index every live path decides 0 and is charged for disagreeing with that value. On an information index every live path is split into two candidates. The best candidates by metric survive, sorted into the slots. The unit reports the hard decisions and the parent of every slot to the tree-update logic, and keeps the path metrics and the decided bit histories for the stage that checks the paths.

While every frozen LLR in the current block agrees with 0, the list is held to two paths. The first frozen disagreement opens it up to the full build-time list size for the rest of the block. Clean blocks therefore carry fewer paths and less work.

Each bit index is taken through a valid/ready handshake. The unit stalls for one cycle after each accepted index while it ranks the candidates. A done pulse marks the result of the last index of the block.

Top module: `list_path_decider`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid`, `done`, `out_count`, `out_bits`, `out_parent`, `out_metric` and `out_hist` are all 0.
- R2: An index is accepted on a clock edge with `in_valid` and `in_ready` both high. `in_ready` is 0 in the following cycle and 1 again after that. The result is presented with `out_valid` high for one cycle, in the cycle after the stall cycle. All outputs except `out_valid` and `done` hold their values until the next result.
- R3: On a frozen index every live slot decides 0 and keeps its place, with `out_parent` equal to its own slot number. Its metric grows by |LLR| when the LLR is negative and is otherwise unchanged. The path count does not change.
- R4: On an information index the hard decision of a path is 1 when its LLR is negative and 0 otherwise. The candidate that keeps the hard decision keeps the metric. The candidate with the flipped bit adds |LLR|. A lower metric is a better path.
- R5: Candidates are numbered 2*p+k, where p is the parent slot and k=0 is the hard-decision candidate. Survivors fill slots from 0 in ascending metric order. Ties go to the lower candidate number. The new count is the smaller of twice the live count and the current cap.
- R6: The cap is 2 while no frozen index of the current block has seen a negative LLR on a live path. After the first such index, the cap is LIST until the block ends.
- R7: Slot s history is `out_hist[s*NBITS +: NBITS]`, and bit j holds the decision taken at index j. A surviving candidate inherits its parent's history. Slots at or above `out_count` read metric 0, history 0, decision 0 and parent 0. LLR of slot s is `in_llr[s*LLRW +: LLRW]`, metric of slot s is `out_metric[s*PMW +: PMW]`, and parent of slot s is `out_parent[s*clog2(LIST) +: clog2(LIST)]`.
- R8: Metrics saturate at 2^PMW-1 instead of wrapping.
- R9: A block is NBITS indexes long. Its first index starts from a single path in slot 0 with metric 0 and an empty history. `done` is high together with `out_valid` for the result of index NBITS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Bit index offered |
| in_ready | output | 1 | Unit can accept a bit index |
| in_frozen | input | 1 | Offered index is frozen |
| in_llr | input | LIST*LLRW | Signed LLR per slot |
| out_valid | output | 1 | Decision result present |
| out_bits | output | LIST | Hard decision per slot |
| out_parent | output | LIST*clog2(LIST) | Parent slot of each slot |
| out_count | output | clog2(LIST+1) | Live path count |
| out_metric | output | LIST*PMW | Path metric per slot |
| out_hist | output | LIST*NBITS | Decided bit history per slot |
| done | output | 1 | Last index of the block decided |

## Verification
The bench builds the unit with LIST=4, NBITS=16, LLRW=6 and PMW=8. A list of four is large enough to show both the two-path cap on clean blocks and the growth to four paths after a frozen disagreement. An 8-bit metric lets sixteen maximum-magnitude frozen charges reach saturation within one block. All-zero LLRs drive the tie-breaking order, and back-to-back blocks show the restart to a single path.

// File: rtl/list_path_decider.sv
module list_path_decider #(
  parameter int LIST  = 4,
  parameter int NBITS = 16,
  parameter int LLRW  = 6,
  parameter int PMW   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_frozen,
  input  logic [LIST*LLRW-1:0]       in_llr,
  output logic                       out_valid,
  output logic [LIST-1:0]            out_bits,
  output logic [LIST*$clog2(LIST)-1:0] out_parent,
  output logic [$clog2(LIST+1)-1:0]  out_count,
  output logic [LIST*PMW-1:0]        out_metric,
  output logic [LIST*NBITS-1:0]      out_hist,
  output logic                       done
);
  localparam int IW = $clog2(LIST);
  localparam int CW = $clog2(LIST+1);
  localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int NC = 2*LIST;
  localparam int RW = $clog2(NC+1);
  localparam logic [PMW-1:0] PM_MAX = '1;

  logic                 pend, fz_q, clean;
  logic [LIST*LLRW-1:0] llr_q;
  logic [BW-1:0]        cnt;
  logic [CW-1:0]        nact;
  logic [PMW-1:0]       pm   [LIST];
  logic [NBITS-1:0]     hist [LIST];

  assign in_ready  = !pend;
  assign out_count = nact;

  wire          first     = (cnt == '0);
  wire [CW-1:0] cur_n     = first ? CW'(1) : nact;
  wire          cur_clean = first | clean;

  logic [LIST-1:0]  act, neg;
  logic [PMW-1:0]   base [LIST], bumped [LIST];
  logic [NBITS-1:0] hbase [LIST];

  for (genvar gi = 0; gi < LIST; gi++) begin : g_path
    wire signed [LLRW-1:0] l   = llr_q[gi*LLRW +: LLRW];
    wire [LLRW-1:0]        mag = l[LLRW-1] ? LLRW'(-l) : LLRW'(l);
    wire [PMW:0]           sum = {1'b0, base[gi]} + (PMW+1)'(mag);
    assign act[gi]    = 32'(gi) < 32'(cur_n);
    assign neg[gi]    = l[LLRW-1];
    assign base[gi]   = first ? '0 : pm[gi];
    assign hbase[gi]  = first ? '0 : hist[gi];
    assign bumped[gi] = sum[PMW] ? PM_MAX : sum[PMW-1:0];
    assign out_metric[gi*PMW +: PMW]     = pm[gi];
    assign out_hist[gi*NBITS +: NBITS]   = hist[gi];
  end

  logic [NC-1:0]  cv, cb;
  logic [PMW-1:0] cm [NC];

  for (genvar gc = 0; gc < NC; gc++) begin : g_cand
    assign cv[gc] = act[gc/2];
    assign cb[gc] = neg[gc/2] ^ gc[0];
    assign cm[gc] = gc[0] ? bumped[gc/2] : base[gc/2];
  end

  logic [RW-1:0]    rank [NC];
  logic [PMW-1:0]   nx_pm [LIST];
  logic [NBITS-1:0] nx_h  [LIST];
  logic [LIST-1:0]  nx_b;
  logic [IW-1:0]    nx_p  [LIST];
  logic [CW-1:0]    nx_n;
  logic             nx_clean;
  int               keep;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      rank[c] = '0;
      for (int d = 0; d < NC; d++)
        if (cv[d] && (cm[d] < cm[c] || (cm[d] == cm[c] && d < c)))
          rank[c] = rank[c] + RW'(1);
    end
  end

  always_comb begin
    keep     = 0;
    nx_b     = '0;
    nx_n     = cur_n;
    nx_clean = cur_clean & ~(fz_q & |(neg & act));
    for (int s = 0; s < LIST; s++) begin
      nx_pm[s] = '0;
      nx_h[s]  = '0;
      nx_p[s]  = '0;
    end
    if (fz_q) begin
      for (int s = 0; s < LIST; s++)
        if (act[s]) begin
          nx_pm[s]     = neg[s] ? bumped[s] : base[s];
          nx_h[s]      = hbase[s];
          nx_h[s][cnt] = 1'b0;
          nx_p[s]      = IW'(s);
        end
    end else begin
      keep = (cur_clean && LIST > 2) ? 2 : LIST;
      if (2*int'(cur_n) < keep) keep = 2*int'(cur_n);
      nx_n = CW'(keep);
      for (int c = 0; c < NC; c++)
        for (int s = 0; s < LIST; s++)
          if (cv[c] && rank[c] == RW'(s) && s < keep) begin
            nx_pm[s]     = cm[c];
            nx_b[s]      = cb[c];
            nx_p[s]      = IW'(c/2);
            nx_h[s]      = hbase[c/2];
            nx_h[s][cnt] = cb[c];
          end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;  fz_q <= 1'b0;  llr_q <= '0;  clean <= 1'b1;
      cnt  <= '0;    nact <= '0;    out_valid <= 1'b0;  done <= 1'b0;
      out_bits <= '0;  out_parent <= '0;
      for (int s = 0; s < LIST; s++) begin
        pm[s]   <= '0;
        hist[s] <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      if (in_valid && !pend) begin
        pend  <= 1'b1;
        fz_q  <= in_frozen;
        llr_q <= in_llr;
      end
      if (pend) begin
        pend      <= 1'b0;
        nact      <= nx_n;
        clean     <= nx_clean;
        out_bits  <= nx_b;
        out_valid <= 1'b1;
        done      <= (cnt == BW'(NBITS-1));
        cnt       <= (cnt == BW'(NBITS-1)) ? '0 : cnt + BW'(1);
        for (int s = 0; s < LIST; s++) begin
          pm[s]   <= nx_pm[s];
          hist[s] <= nx_h[s];
          out_parent[s*IW +: IW] <= nx_p[s];
        end
      end
    end
  end
endmodule

// File: rtl/list_path_decider_chk.sv
module list_path_decider_chk #(
  parameter int LIST  = 4,
  parameter int NBITS = 16,
  parameter int LLRW  = 6,
  parameter int PMW   = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic                         in_frozen,
  input logic [LIST*LLRW-1:0]         in_llr,
  input logic                         out_valid,
  input logic [LIST-1:0]              out_bits,
  input logic [LIST*$clog2(LIST)-1:0] out_parent,
  input logic [$clog2(LIST+1)-1:0]    out_count,
  input logic [LIST*PMW-1:0]          out_metric,
  input logic [LIST*NBITS-1:0]        out_hist,
  input logic                         done
);
  localparam int CW = $clog2(LIST+1);

  AST_STALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);  // R2
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);  // R2
  AST_FROZEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && in_ready && in_frozen, 2)) |-> (out_bits == '0));  // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count >= CW'(1) && out_count <= CW'(LIST)));  // R5
  AST_SORTED_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && in_ready && !in_frozen, 2) && out_count >= CW'(2))
      |-> (out_metric[0 +: PMW] <= out_metric[PMW +: PMW]));  // R5
  AST_DONE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);  // R9
endmodule

bind list_path_decider list_path_decider_chk #(
  .LIST(LIST), .NBITS(NBITS), .LLRW(LLRW), .PMW(PMW)
) u_chk (.*);

// File: tb/list_path_decider_tb.sv
module list_path_decider_tb;
  localparam int L = 4, NB = 16, LW = 6, PW = 8, IW = 2, CW = 3;
  localparam int PMAX = 255;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_frozen = 0;
  logic [L*LW-1:0] in_llr = '0;
  logic in_ready, out_valid, done;
  logic [L-1:0] out_bits;
  logic [L*IW-1:0] out_parent;
  logic [CW-1:0] out_count;
  logic [L*PW-1:0] out_metric;
  logic [L*NB-1:0] out_hist;

  always #4 clk = ~clk;

  list_path_decider #(.LIST(L), .NBITS(NB), .LLRW(LW), .PMW(PW)) u_dut (.*);

  int errs = 0, checks = 0, cyc = 0;
  int vec[L];
  int m_n, m_cnt, m_pm[L], m_h[L], e_b[L], e_p[L];
  bit m_clean, e_done;
  int max_cnt, max_pm;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  task automatic model(bit fz);
    int cm[2*L], cbv[2*L], used[2*L];
    int npm[L], nh[L], keep, best;
    if (m_cnt == 0) begin
      m_n = 1; m_clean = 1;
      for (int i = 0; i < L; i++) begin m_pm[i] = 0; m_h[i] = 0; end
    end
    for (int i = 0; i < L; i++) begin e_b[i] = 0; e_p[i] = 0; npm[i] = 0; nh[i] = 0; end
    if (fz) begin
      for (int i = 0; i < m_n; i++) begin
        e_p[i] = i; npm[i] = m_pm[i]; nh[i] = m_h[i];
        if (vec[i] < 0) begin
          npm[i] = (m_pm[i] - vec[i] > PMAX) ? PMAX : m_pm[i] - vec[i];
          m_clean = 0;
        end
      end
    end else begin
      for (int c = 0; c < 2*L; c++) begin
        int p, a, hb;
        p = c / 2; used[c] = (p < m_n) ? 0 : 1;
        a = vec[p] < 0 ? -vec[p] : vec[p];
        hb = vec[p] < 0 ? 1 : 0;
        cbv[c] = (c % 2) ? 1 - hb : hb;
        cm[c] = (c % 2) ? ((m_pm[p] + a > PMAX) ? PMAX : m_pm[p] + a) : m_pm[p];
      end
      keep = m_clean ? 2 : L;
      if (2*m_n < keep) keep = 2*m_n;
      for (int s = 0; s < keep; s++) begin
        best = -1;
        for (int c = 0; c < 2*L; c++)
          if (!used[c] && (best < 0 || cm[c] < cm[best])) best = c;
        used[best] = 1;
        e_b[s] = cbv[best]; e_p[s] = best / 2; npm[s] = cm[best];
        nh[s] = m_h[best/2] | (cbv[best] << m_cnt);
      end
      m_n = keep;
    end
    for (int i = 0; i < L; i++) begin m_pm[i] = npm[i]; m_h[i] = nh[i]; end
    e_done = (m_cnt == NB-1);
    m_cnt = (m_cnt + 1) % NB;
  endtask

  task automatic send(bit fz);
    @(negedge clk);
    in_valid = 1; in_frozen = fz;
    for (int i = 0; i < L; i++) in_llr[i*LW +: LW] = LW'(vec[i]);
    @(negedge clk);
    in_valid = 0;
    chk("R2", "ready in stall cycle", int'(in_ready), 0);
    chk("R2", "valid in stall cycle", int'(out_valid), 0);
    model(fz);
    @(negedge clk);
    chk("R2", "out_valid", int'(out_valid), 1);
    chk("R9", "done", int'(done), int'(e_done));
    chk(fz ? "R3" : "R5", "count", int'(out_count), m_n);
    for (int s = 0; s < L; s++) begin
      chk(fz ? "R3" : "R4", $sformatf("bit slot%0d", s), int'(out_bits[s]), e_b[s]);
      chk(fz ? "R3" : "R5", $sformatf("parent slot%0d", s), int'(out_parent[s*IW +: IW]), e_p[s]);
      chk(fz ? "R3" : "R4", $sformatf("metric slot%0d", s), int'(out_metric[s*PW +: PW]), m_pm[s]);
      chk("R7", $sformatf("history slot%0d", s), int'(out_hist[s*NB +: NB]), m_h[s]);
      if (int'(out_metric[s*PW +: PW]) > max_pm) max_pm = int'(out_metric[s*PW +: PW]);
    end
    if (int'(out_count) > max_cnt) max_cnt = int'(out_count);
  endtask

  task automatic run_block(int mask, int mode);
    for (int j = 0; j < NB; j++) begin
      bit fz;
      fz = mask[j];
      for (int i = 0; i < L; i++) begin
        case (mode)
          0: vec[i] = fz ? int'($urandom_range(0, 31)) : int'($urandom_range(0, 63)) - 32;
          1: vec[i] = (fz && j == 1) ? -5 : int'($urandom_range(0, 63)) - 32;
          2: vec[i] = -32;
          3: vec[i] = (j == 0) ? -1 : 0;
          default: vec[i] = int'($urandom_range(0, 63)) - 32;
        endcase
      end
      send(fz);
    end
  endtask

  initial begin
    void'($urandom(7));
    m_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R1", "ready", int'(in_ready), 1);
    chk("R1", "valid", int'(out_valid), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "count", int'(out_count), 0);
    chk("R1", "metrics", int'(out_metric != '0), 0);
    chk("R1", "histories", int'(out_hist != '0), 0);
    rst_n = 1;

    max_cnt = 0;
    run_block(16'h00B7, 0);
    chk("R6", "clean block peak count", max_cnt, 2);

    max_cnt = 0;
    run_block(16'h0003, 1);
    chk("R6", "open block peak count", max_cnt, 4);

    max_pm = 0;
    run_block(16'hFFFF, 2);
    chk("R8", "saturated metric", max_pm, PMAX);
    chk("R8", "slot0 metric at block end", int'(out_metric[0 +: PW]), PMAX);

    run_block(16'h0001, 3);
    run_block(16'h5555, 4);
    run_block(16'h0F0F, 4);
    run_block(16'h0000, 4);

    chk("R9", "single path restart", int'(out_count), m_n);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule